// File: doc/BRIEF.md
# Bus Cycle Timer with Cycle-Master Trigger

This block holds the cycle timer of a serial-bus node: a 32-bit register split into a seconds field, a cycle-count field and a cycle-offset field. The offset advances on each timer clock enable. The cycle count advances either when the offset wraps or on a rising edge of an external cycle-sync input, depending on a source-select control bit. The host can load the whole register at any time. When the timer is stopped, the register is an ordinary read/write register for test use.

Each time the cycle count advances, the block decides whether the node must send a cycle-start packet. It raises a one-cycle request only when the cycle-master control bit is set and the node is the bus root. A cycle-timeout event turns the master function off and keeps it off while the control bit stays set. Software re-arms it by clearing the bit and then setting it again. Packet building, arbitration and the PHY side belong to other blocks.

Top module: `cycle_timer_top`

## Requirements
- R1: `timer_val` packs seconds in bits [31:25], cycle count in bits [24:12] and cycle offset in bits [11:0]. A synchronous reset clears all three fields, `start_req` and the timeout latch.
- R2: While `cfg_run` is 1, each clock with `tick_en` high advances the offset by one. From 3071 (or any larger loaded value) it goes to 0.
- R3: With `cfg_ext_src` = 0, the cycle count advances by one on the clock where the offset wraps. It goes from 7999 to 0, and that step adds one to the seconds field, which wraps modulo 128.
- R4: While `cfg_run` is 0, neither `tick_en` nor `sync_in` changes the register. It only changes through host writes.
- R5: With `cfg_ext_src` = 1 and `cfg_run` = 1, a rising edge on `sync_in` goes through two synchronizing flops and an edge detector. On the third clock edge after the input rises, the count advances and the offset clears. A level held high gives only one step. In this mode an offset wrap does not advance the count. With `cfg_ext_src` = 0, `sync_in` is ignored.
- R6: A host write (`host_wr` = 1) loads `host_wdata` into the register on the next edge. It takes priority over any advance in the same cycle, and it never produces `start_req`.
- R7: `start_req` is high for exactly one cycle, on the same edge that makes the advanced count visible. This happens only if `cfg_master` = 1, `is_root` = 1 and the master function is not timed out.
- R8: A `timeout_evt` pulse while `cfg_master` = 1 latches the master function off. `master_active` (= `cfg_master` and not timed out) drops to 0 and no further `start_req` is issued, although `cfg_master` stays 1.
- R9: After a timeout, holding `cfg_master` at 0 for at least one clock and then setting it again restores `master_active` = 1 and the `start_req` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Timer clock enable; one offset step per high cycle |
| sync_in | input | 1 | External cycle-sync input, asynchronous |
| cfg_run | input | 1 | Timer run enable |
| cfg_ext_src | input | 1 | 1: count advances on sync_in rising edge; 0: on offset wrap |
| cfg_master | input | 1 | Cycle-master enable |
| is_root | input | 1 | Node is bus root |
| timeout_evt | input | 1 | Cycle-timeout event pulse |
| host_wr | input | 1 | Host write strobe for the timer register |
| host_wdata | input | 32 | Host write data, same layout as timer_val |
| timer_val | output | 32 | Current timer register value |
| start_req | output | 1 | One-cycle cycle-start transmit request |
| master_active | output | 1 | Cycle-master function enabled and not timed out |

## Verification
The hardest cases to reach are the rollovers: offset 3071 with count 7999, and seconds 127 at the same moment. The ticks alone would need millions of cycles to get there. The bench uses host writes to place the register one or a few ticks before each rollover, then lets it count through. The timeout re-arm sequence is built the same way. The register is preloaded near an offset wrap after a timeout, to show that no request appears while the control bit stays set. The bit is then dropped for one clock and raised again, and a fresh wrap shows the pulse coming back.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int DEF_OFF_W    = 12;
  localparam int DEF_CNT_W    = 13;
  localparam int DEF_SEC_W    = 7;
  localparam int DEF_OFF_LAST = 3071;
  localparam int DEF_CNT_LAST = 7999;
  localparam int DEF_SYNC_STG = 2;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_WRAP = 2'd1,
    STEP_EDGE = 2'd2
  } step_e;
endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R5
endmodule

// File: rtl/ct_fields.sv
module ct_fields
  import ct_pkg::*;
#(
  parameter int OFF_W    = DEF_OFF_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int SEC_W    = DEF_SEC_W,
  parameter int OFF_LAST = DEF_OFF_LAST,
  parameter int CNT_LAST = DEF_CNT_LAST,
  localparam int TV_W    = SEC_W + CNT_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            ext_src,
  input  logic            tick,
  input  logic            sync_rise,
  input  logic            wr_en,
  input  logic [TV_W-1:0] wr_data,
  output logic [TV_W-1:0] value,
  output logic            cnt_step,
  output step_e           step_kind
);
  localparam logic [OFF_W-1:0] OFF_LAST_V = OFF_W'(OFF_LAST);
  localparam logic [CNT_W-1:0] CNT_LAST_V = CNT_W'(CNT_LAST);

  logic [OFF_W-1:0] off_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;
  logic             off_wrap;
  logic             ext_hit;
  logic             cnt_wrap;

  function automatic logic [OFF_W-1:0] off_adv(input logic [OFF_W-1:0] o);
    return (o >= OFF_LAST_V) ? '0 : o + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_adv(input logic [CNT_W-1:0] c);
    return (c >= CNT_LAST_V) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [SEC_W-1:0] sec_adv(input logic [SEC_W-1:0] s);
    return s + 1'b1;
  endfunction

  always_comb begin
    off_wrap = run && tick && (off_q >= OFF_LAST_V);
    ext_hit  = run && ext_src && sync_rise;
    cnt_wrap = cnt_q >= CNT_LAST_V;
    if (!run || wr_en)             step_kind = STEP_NONE;
    else if (ext_hit)              step_kind = STEP_EDGE;
    else if (!ext_src && off_wrap) step_kind = STEP_WRAP;
    else                           step_kind = STEP_NONE;
    cnt_step = (step_kind != STEP_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
      cnt_q <= '0;
      sec_q <= '0;
    end else if (wr_en) begin
      {sec_q, cnt_q, off_q} <= wr_data;
    end else if (run) begin
      if (ext_hit)   off_q <= '0;
      else if (tick) off_q <= off_adv(off_q);
      if (cnt_step) begin
        cnt_q <= cnt_adv(cnt_q);
        if (cnt_wrap) sec_q <= sec_adv(sec_q);
      end
    end
  end

  assign value = {sec_q, cnt_q, off_q};

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(value)); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (value == $past(wr_data))); // R6
  AST_OFF_WRAP: assert property (@(posedge clk) disable iff (rst)
    (off_wrap && !wr_en && !ext_hit) |=> (off_q == '0)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_step && !cnt_wrap) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (step_kind == STEP_EDGE) |=> (off_q == '0)); // R5
endmodule

// File: rtl/ct_master.sv
module ct_master (
  input  logic clk,
  input  logic rst,
  input  logic cfg_master,
  input  logic is_root,
  input  logic timeout,
  input  logic cnt_step,
  output logic start_req,
  output logic active
);
  logic tripped;

  always_ff @(posedge clk) begin
    if (rst) begin
      tripped   <= 1'b0;
      start_req <= 1'b0;
    end else begin
      if (!cfg_master)  tripped <= 1'b0;
      else if (timeout) tripped <= 1'b1;
      start_req <= cnt_step && cfg_master && !tripped && !timeout && is_root;
    end
  end

  assign active = cfg_master && !tripped;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !start_req); // R7
  AST_START_NEEDS_ROOT: assert property (@(posedge clk) disable iff (rst)
    start_req |-> $past(is_root)); // R7
  AST_TRIP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    tripped |-> !start_req); // R8
  AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (tripped && cfg_master) |=> tripped); // R8
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |=> !tripped); // R9
endmodule

// File: rtl/cycle_timer_top.sv
module cycle_timer_top
  import ct_pkg::*;
#(
  parameter int OFF_W    = DEF_OFF_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int SEC_W    = DEF_SEC_W,
  parameter int OFF_LAST = DEF_OFF_LAST,
  parameter int CNT_LAST = DEF_CNT_LAST,
  parameter int SYNC_STG = DEF_SYNC_STG,
  localparam int TV_W    = SEC_W + CNT_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic            sync_in,
  input  logic            cfg_run,
  input  logic            cfg_ext_src,
  input  logic            cfg_master,
  input  logic            is_root,
  input  logic            timeout_evt,
  input  logic            host_wr,
  input  logic [TV_W-1:0] host_wdata,
  output logic [TV_W-1:0] timer_val,
  output logic            start_req,
  output logic            master_active
);
  logic  sync_rise;
  logic  cnt_step;
  step_e step_kind;

  ct_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sync_in),
    .rise     (sync_rise)
  );

  ct_fields #(
    .OFF_W(OFF_W), .CNT_W(CNT_W), .SEC_W(SEC_W),
    .OFF_LAST(OFF_LAST), .CNT_LAST(CNT_LAST)
  ) u_fields (
    .clk       (clk),
    .rst       (rst),
    .run       (cfg_run),
    .ext_src   (cfg_ext_src),
    .tick      (tick_en),
    .sync_rise (sync_rise),
    .wr_en     (host_wr),
    .wr_data   (host_wdata),
    .value     (timer_val),
    .cnt_step  (cnt_step),
    .step_kind (step_kind)
  );

  ct_master u_master (
    .clk        (clk),
    .rst        (rst),
    .cfg_master (cfg_master),
    .is_root    (is_root),
    .timeout    (timeout_evt),
    .cnt_step   (cnt_step),
    .start_req  (start_req),
    .active     (master_active)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (timer_val == '0 && !start_req)); // R1
  AST_NO_START_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> !start_req); // R6
endmodule

// File: tb/sim_cycle_timer_top.sv
module sim_cycle_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, sync_in = 1'b0;
  logic        cfg_run = 1'b0, cfg_ext_src = 1'b0, cfg_master = 1'b0;
  logic        is_root = 1'b0, timeout_evt = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] timer_val;
  logic        start_req, master_active;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cycle_timer_top u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sync_in(sync_in),
    .cfg_run(cfg_run), .cfg_ext_src(cfg_ext_src), .cfg_master(cfg_master),
    .is_root(is_root), .timeout_evt(timeout_evt), .host_wr(host_wr),
    .host_wdata(host_wdata), .timer_val(timer_val), .start_req(start_req),
    .master_active(master_active)
  );

  // sec, cnt, off, ticks, expected sec, cnt, off (internal source)
  localparam int VEC[6][7] = '{
    '{0,    0,    0,  5,   0,    0,    5},
    '{0,    5, 3070,  2,   0,    6,    0},
    '{3, 7999, 3071,  1,   4,    0,    0},
    '{127,7999,3071,  1,   0,    0,    0},
    '{1,   20,  100,  0,   1,   20,  100},
    '{9, 7998, 3060, 15,   9, 7999,    3}
  };

  function automatic logic [31:0] pk(input int s, input int c, input int o);
    logic [6:0]  sv = 7'(s);
    logic [12:0] cv = 13'(c);
    logic [11:0] ov = 12'(o);
    return {sv, cv, ov};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset value", timer_val, 32'h0);
    chk("R1 reset start_req", {31'b0, start_req}, 32'h0);
    chk("R1 field layout", pk(1, 2, 3), 32'h0200_2003);

    cfg_run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wr(pk(VEC[i][0], VEC[i][1], VEC[i][2]));
      ticks(VEC[i][3]);
      chk($sformatf("R2 R3 vector %0d", i), timer_val, pk(VEC[i][4], VEC[i][5], VEC[i][6]));
    end

    // R4: stopped timer ignores ticks and sync, still writable
    cfg_run = 1'b0;
    wr(pk(5, 100, 200));
    ticks(10);
    sync_in = 1'b1; repeat (4) @(negedge clk); sync_in = 1'b0;
    chk("R4 stopped hold", timer_val, pk(5, 100, 200));
    wr(pk(6, 7, 8));
    chk("R4 plain write", timer_val, pk(6, 7, 8));

    // R6: write beats a same-cycle wrap
    cfg_run = 1'b1;
    host_wdata = pk(1, 2, 3071); host_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; tick_en = 1'b0;
    chk("R6 write priority", timer_val, pk(1, 2, 3071));

    // R5: external source
    cfg_ext_src = 1'b1;
    wr(pk(0, 10, 50));
    sync_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 sync latency", timer_val, pk(0, 10, 50));
    @(negedge clk);
    chk("R5 edge step", timer_val, pk(0, 11, 0));
    repeat (5) @(negedge clk);
    chk("R5 level single step", timer_val, pk(0, 11, 0));
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
    wr(pk(0, 11, 3071));
    ticks(1);
    chk("R5 wrap no count", timer_val, pk(0, 11, 0));
    cfg_ext_src = 1'b0;
    wr(pk(0, 20, 5));
    sync_in = 1'b1; repeat (4) @(negedge clk); sync_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 sync ignored internal", timer_val, pk(0, 20, 5));

    // R7: start request
    cfg_master = 1'b1; is_root = 1'b1;
    wr(pk(0, 0, 3070));
    ticks(1);
    chk("R7 no req before wrap", {31'b0, start_req}, 32'h0);
    ticks(1);
    chk("R7 req on step", {31'b0, start_req}, 32'h1);
    chk("R7 count stepped", timer_val, pk(0, 1, 0));
    @(negedge clk);
    chk("R7 single pulse", {31'b0, start_req}, 32'h0);
    is_root = 1'b0;
    wr(pk(0, 0, 3070));
    ticks(2);
    chk("R7 not root", {31'b0, start_req}, 32'h0);
    is_root = 1'b1;

    // R8: timeout latch
    chk("R8 active before", {31'b0, master_active}, 32'h1);
    timeout_evt = 1'b1; @(negedge clk); timeout_evt = 1'b0;
    chk("R8 active dropped", {31'b0, master_active}, 32'h0);
    wr(pk(0, 0, 3070));
    ticks(2);
    chk("R8 no req after timeout", {31'b0, start_req}, 32'h0);
    chk("R8 count still steps", timer_val, pk(0, 1, 0));

    // R9: re-arm
    cfg_master = 1'b0; @(negedge clk); cfg_master = 1'b1; #1;
    chk("R9 active rearmed", {31'b0, master_active}, 32'h1);
    wr(pk(0, 0, 3070));
    ticks(2);
    chk("R9 req restored", {31'b0, start_req}, 32'h1);

    // R1: reset mid-run clears fields and latch
    timeout_evt = 1'b1; @(negedge clk); timeout_evt = 1'b0;
    wr(pk(3, 4, 5));
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 reset clears fields", timer_val, 32'h0);
    chk("R1 reset clears latch", {31'b0, master_active}, 32'h1);

    finish_run();
  end
endmodule